// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the target side of a four-byte serial programming link. A host drives a serial clock, a data line and a framing reset pin. The block samples all three with its own system clock and shifts frames in most significant bit first. It answers on its serial output. The block holds a small flash model organised in 64-word pages, a word-wide page buffer and a byte-wide EEPROM model. Frames can load the buffer, commit it to a flash page, write a single EEPROM byte, erase everything, or read back any location.

Each received byte is sent back on the serial output during the following byte. A host can therefore check that it is in step: during the third byte of the enable frame it must see the enable frame's second byte. The only exception is a read frame. In a read, the addressed content replaces the echo during the fourth byte. After a commit, an EEPROM write or an erase, a busy output stays high for a fixed number of system clocks. Any frame that completes while busy is high is dropped. Raising the framing reset pin puts the bit counter back to the start of a frame, so a host that has slipped can start again.

Top module: `spi_prog_target`

## Requirements
- R1: The data line is captured on each rising edge of the serial clock and the serial output changes only after a falling edge. Both edges are seen after a three-flop synchroniser. Each clock phase must last at least 3 system clocks.
- R2: Frames are four bytes, most significant bit first. Each received byte appears on the serial output during the next byte. Byte 0 of a frame carries byte 3 of the previous frame. The bit and byte counters return to zero after the last bit of a frame.
- R3: The enable frame is 0xAC, 0x53, any, any. Until it has been accepted, every other frame is ignored: writes change nothing, busy stays low, and reads return the plain echo.
- R4: Frame 0x40, -, w, d stores d as the low byte of buffer word w[5:0] and marks that word. Frame 0x48, -, w, d stores d as the high byte only if the word is marked; otherwise it is ignored.
- R5: Frame 0x4C, hi, lo, - copies all 64 buffer words into the flash page selected by the upper bits of the word address {hi,lo}. It then returns the buffer to 0xFFFF with all marks cleared. Other pages are unchanged.
- R6: Frame 0xC0, -, a, d writes d to EEPROM byte a. The new value replaces the old one fully.
- R7: Frame 0xAC, b, -, - with b[7:5] = 100 sets every flash word and every EEPROM byte to all ones.
- R8: Read frames return the content during byte 3. Frame 0x20, hi, lo, - returns the flash low byte at word {hi,lo}. Frame 0x28 returns the high byte. Frame 0xA0, -, a, - returns EEPROM byte a.
- R9: While the synchronised framing reset is high, the bit and byte counters are held at zero, the pending output byte is cleared and the enable is withdrawn. Memory contents are kept.
- R10: A commit or EEPROM write raises busy for WRITE_CYCLES system clocks. An erase raises it for ERASE_CYCLES. Every frame that completes while busy is high is dropped, and a read in that window returns the echo.
- R11: After system reset, the serial output is 0, busy is low, the block is not enabled and every memory location reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| prog_rst | input | 1 | Framing reset from the host, active high, asynchronous to clk |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| busy | output | 1 | High while a write or erase window is open |

## Verification
The assertions assume the host holds each serial clock phase long enough for both edges to pass the synchroniser. They also assume the data line is steady around each rising edge, and that framing reset pulses last several system clocks. The bench keeps within these limits by driving every serial clock phase for five system clocks. It changes the data line only while the serial clock is low, holds the framing reset for four clocks, and lowers the serial clock before each framing reset pulse.

// File: rtl/spi_prog_target.sv
module spi_prog_target #(
  parameter int PAGE_BITS    = 2,
  parameter int EE_ABITS     = 6,
  parameter int WRITE_CYCLES = 600,
  parameter int ERASE_CYCLES = 900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_rst,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy
);
  localparam int FA    = 6 + PAGE_BITS;
  localparam int FWORD = 1 << FA;
  localparam int EBYTE = 1 << EE_ABITS;
  localparam int MAXC  = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [FA-1:0] PG_MASK = ~FA'(63);

  localparam logic [7:0] OP_EN0 = 8'hAC, OP_EN1 = 8'h53;
  localparam logic [7:0] OP_LDL = 8'h40, OP_LDH = 8'h48, OP_WPG = 8'h4C;
  localparam logic [7:0] OP_WEE = 8'hC0, OP_RDL = 8'h20, OP_RDH = 8'h28, OP_REE = 8'hA0;

  logic [2:0] sck_s;
  logic [1:0] mosi_s, rst_q;
  logic       rst_s, sck_rise, sck_fall;

  logic [6:0] rx_sh;
  logic [7:0] tx_sh, b0, b1, b2, rx_byte, rd_data;
  logic [2:0] bit_cnt;
  logic [1:0] byte_idx;
  logic       enabled, miso_q, frame_done, last_bit, idle, rd_hit;
  logic [CW-1:0] busy_cnt;

  logic [15:0] flash [FWORD];
  logic [7:0]  eep   [EBYTE];
  logic [15:0] pbuf  [64];
  logic [63:0] lo_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
      rst_q  <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      mosi_s <= {mosi_s[0], mosi};
      rst_q  <= {rst_q[0], prog_rst};
    end

  assign rst_s      = rst_q[1];
  assign sck_rise   = sck_s[1] & ~sck_s[2];
  assign sck_fall   = ~sck_s[1] & sck_s[2];
  assign rx_byte    = {rx_sh, mosi_s[1]};
  assign last_bit   = sck_rise && (bit_cnt == 3'd7) && !rst_s;
  assign frame_done = last_bit && (byte_idx == 2'd3);
  assign idle       = (busy_cnt == '0);
  assign busy       = !idle;
  assign miso       = miso_q;

  assign rd_hit = enabled && idle && (b0 == OP_RDL || b0 == OP_RDH || b0 == OP_REE);

  always_comb begin
    rd_data = rx_byte;
    case (b0)
      OP_RDL:  rd_data = flash[FA'({b1, rx_byte})][7:0];
      OP_RDH:  rd_data = flash[FA'({b1, rx_byte})][15:8];
      OP_REE:  rd_data = eep[EE_ABITS'(rx_byte)];
      default: rd_data = rx_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh    <= '0;
      tx_sh    <= '0;
      b0       <= '0;
      b1       <= '0;
      b2       <= '0;
      bit_cnt  <= '0;
      byte_idx <= '0;
      enabled  <= 1'b0;
      miso_q   <= 1'b0;
      busy_cnt <= '0;
      lo_ok    <= '0;
      for (int i = 0; i < FWORD; i++) flash[i] <= 16'hFFFF;
      for (int i = 0; i < EBYTE; i++) eep[i] <= 8'hFF;
      for (int i = 0; i < 64; i++) pbuf[i] <= 16'hFFFF;
    end else begin
      if (!idle) busy_cnt <= busy_cnt - 1'b1;
      if (rst_s) begin
        bit_cnt  <= '0;
        byte_idx <= '0;
        enabled  <= 1'b0;
        tx_sh    <= '0;
      end else begin
        if (sck_fall) begin
          miso_q <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
        if (sck_rise) begin
          rx_sh   <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (last_bit) begin
          byte_idx <= byte_idx + 1'b1;
          tx_sh    <= (byte_idx == 2'd2 && rd_hit) ? rd_data : rx_byte;
          case (byte_idx)
            2'd0:    b0 <= rx_byte;
            2'd1:    b1 <= rx_byte;
            2'd2:    b2 <= rx_byte;
            default: ;
          endcase
        end
        if (frame_done && idle) begin
          if (b0 == OP_EN0 && b1 == OP_EN1) begin
            enabled <= 1'b1;
          end else if (enabled) begin
            case (b0)
              OP_LDL: begin
                pbuf[6'(b2)][7:0] <= rx_byte;
                lo_ok[6'(b2)]     <= 1'b1;
              end
              OP_LDH: if (lo_ok[6'(b2)]) pbuf[6'(b2)][15:8] <= rx_byte;
              OP_WPG: begin
                for (int i = 0; i < 64; i++) begin
                  flash[(FA'({b1, b2}) & PG_MASK) | FA'(i)] <= pbuf[i];
                  pbuf[i] <= 16'hFFFF;
                end
                lo_ok    <= '0;
                busy_cnt <= CW'(WRITE_CYCLES);
              end
              OP_WEE: begin
                eep[EE_ABITS'(b2)] <= rx_byte;
                busy_cnt           <= CW'(WRITE_CYCLES);
              end
              OP_EN0: if (b1[7:5] == 3'b100) begin
                for (int i = 0; i < FWORD; i++) flash[i] <= 16'hFFFF;
                for (int i = 0; i < EBYTE; i++) eep[i] <= 8'hFF;
                busy_cnt <= CW'(ERASE_CYCLES);
              end
              default: ;
            endcase
          end
        end
      end
    end
endmodule

// File: rtl/spi_prog_target_chk.sv
module spi_prog_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       miso,
  input logic       busy,
  input logic       sck_fall,
  input logic       rst_s,
  input logic       frame_done,
  input logic       enabled,
  input logic [2:0] bit_cnt,
  input logic [1:0] byte_idx
);
  p_miso_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> $past(sck_fall));

  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (bit_cnt == 3'd0 && byte_idx == 2'd0));

  p_enable_by_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enabled) |-> $past(frame_done));

  p_resync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_s |=> (bit_cnt == 3'd0 && byte_idx == 2'd0 && !enabled));

  p_busy_from_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_done));
endmodule

bind spi_prog_target spi_prog_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .miso(miso), .busy(busy), .sck_fall(sck_fall),
  .rst_s(rst_s), .frame_done(frame_done), .enabled(enabled),
  .bit_cnt(bit_cnt), .byte_idx(byte_idx)
);

// File: tb/spi_prog_target_tb_top.sv
module spi_prog_target_tb_top;
  localparam int HP = 5;

  logic clk = 1'b0, rst_n = 1'b0, prog_rst = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, busy;
  int checks = 0, errors = 0;
  logic [31:0] r;

  always #2 clk = ~clk;

  spi_prog_target dut_i (
    .clk(clk), .rst_n(rst_n), .prog_rst(prog_rst), .sck(sck),
    .mosi(mosi), .miso(miso), .busy(busy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] c0, c1, c2, c3, output logic [31:0] got);
    logic [31:0] w;
    w = {c0, c1, c2, c3};
    for (int k = 31; k >= 0; k--) begin
      @(negedge clk) mosi = w[k];
      repeat (HP) @(negedge clk);
      got[k] = miso;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] op, input logic [15:0] a, output logic [7:0] v);
    logic [31:0] g;
    xfer(op, a[15:8], a[7:0], 8'h00, g);
    v = g[7:0];
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_rst;
    @(negedge clk) sck = 1'b0;
    repeat (3) @(negedge clk);
    prog_rst = 1'b1;
    repeat (4) @(negedge clk);
    prog_rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 miso after reset", 16'(miso), 16'h0);
    chk("R11 busy after reset", 16'(busy), 16'h0);
  endtask

  task automatic t_pre_enable;
    logic [7:0] v;
    rd(8'hA0, 16'h0005, v);
    chk("R3 read before enable echoes", 16'(v), 16'h05);
    xfer(8'hC0, 8'h00, 8'h05, 8'h12, r);
    chk("R3 write before enable no busy", 16'(busy), 16'h0);
  endtask

  task automatic t_enable;
    logic [7:0] v;
    xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
    chk("R2 R1 echo of byte0 in byte1", 16'(r[23:16]), 16'hAC);
    chk("R2 sync echo 0x53 in byte2", 16'(r[15:8]), 16'h53);
    rd(8'hA0, 16'h0005, v);
    chk("R3 R11 ignored write left ff", 16'(v), 16'hFF);
  endtask

  task automatic t_eeprom;
    logic [7:0] v;
    xfer(8'hC0, 8'h00, 8'h07, 8'h3C, r);
    chk("R10 busy after eeprom write", 16'(busy), 16'h1);
    xfer(8'hC0, 8'h00, 8'h08, 8'h77, r);
    wait_idle();
    rd(8'hA0, 16'h0007, v);
    chk("R6 eeprom readback", 16'(v), 16'h3C);
    rd(8'hA0, 16'h0008, v);
    chk("R10 frame in busy dropped", 16'(v), 16'hFF);
    xfer(8'hC0, 8'h00, 8'h07, 8'hC3, r);
    wait_idle();
    rd(8'hA0, 16'h0007, v);
    chk("R6 overwrite replaces", 16'(v), 16'hC3);
  endtask

  task automatic t_page;
    logic [7:0] v;
    xfer(8'h40, 8'h00, 8'h03, 8'h34, r);
    xfer(8'h48, 8'h00, 8'h03, 8'h12, r);
    xfer(8'h48, 8'h00, 8'h04, 8'h99, r);
    xfer(8'h40, 8'h00, 8'h04, 8'h55, r);
    xfer(8'h4C, 8'h00, 8'h40, 8'h00, r);
    chk("R10 busy after page commit", 16'(busy), 16'h1);
    wait_idle();
    rd(8'h20, 16'h0043, v);
    chk("R4 R8 low byte", 16'(v), 16'h34);
    rd(8'h28, 16'h0043, v);
    chk("R4 R8 high byte", 16'(v), 16'h12);
    rd(8'h28, 16'h0044, v);
    chk("R4 high before low ignored", 16'(v), 16'hFF);
    rd(8'h20, 16'h0044, v);
    chk("R4 low after rejected high", 16'(v), 16'h55);
    rd(8'h20, 16'h0003, v);
    chk("R5 other page untouched", 16'(v), 16'hFF);
    xfer(8'h4C, 8'h00, 8'h80, 8'h00, r);
    wait_idle();
    rd(8'h20, 16'h0083, v);
    chk("R5 buffer cleared after commit", 16'(v), 16'hFF);
  endtask

  task automatic t_erase;
    logic [7:0] v;
    xfer(8'hAC, 8'h80, 8'h00, 8'h00, r);
    chk("R7 busy during erase", 16'(busy), 16'h1);
    wait_idle();
    rd(8'h28, 16'h0043, v);
    chk("R7 flash erased", 16'(v), 16'hFF);
    rd(8'hA0, 16'h0007, v);
    chk("R7 eeprom erased", 16'(v), 16'hFF);
  endtask

  task automatic t_resync;
    logic [7:0] v;
    xfer(8'hC0, 8'h00, 8'h09, 8'h5A, r);
    wait_idle();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk) mosi = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    pulse_rst();
    rd(8'hA0, 16'h0009, v);
    chk("R9 enable withdrawn read echoes", 16'(v), 16'h09);
    xfer(8'hAC, 8'h53, 8'h00, 8'hE1, r);
    chk("R9 realigned echo 0x53", 16'(r[15:8]), 16'h53);
    xfer(8'hA0, 8'h00, 8'h09, 8'h00, r);
    chk("R2 byte0 carries previous byte3", 16'(r[31:24]), 16'hE1);
    chk("R9 R8 memory kept", 16'(r[7:0]), 16'h5A);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pre_enable();
    t_enable();
    t_eeprom();
    t_page();
    t_erase();
    t_resync();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule